// File: doc/BRIEF.md
# Physical Memory Permission Checker

This block decides whether a physical memory access may proceed. It holds a parameterised table of protection entries. Each entry has an address-match mode, an address field counted in 1 KB granules, and three independent permission bits for read, write and execute. Each access presents a granule address, an access type and the current privilege mode. The block looks up the entry that decides the access and forms a permission verdict from it.

That verdict is combined with an attribute-check verdict, which another unit computes in parallel and supplies on `attr_ok`. The access is granted only when both verdicts allow it. A denied access raises a fault one cycle after the request, and the fault carries the access type. The table can only be changed from machine mode. A configuration write from any lower mode leaves the table untouched and raises a one-cycle illegal-write flag.

Top module: `pmp_checker`

## Requirements
- R1: After reset, every entry is in match mode off with zero permissions and a zero address. `grant`, `fault`, `fault_type` and `cfg_illegal` read 0.
- R2: A configuration write with `cfg_we`=1 and `cfg_priv`=2'b11 (machine) stores `cfg_mode`, `cfg_perm` and `cfg_addr` into entry `cfg_idx`. It takes effect for requests presented from the next cycle onward.
- R3: A configuration write with `cfg_priv` other than 2'b11 changes no entry. It drives `cfg_illegal` high in the following cycle. `cfg_illegal` is low after every other cycle.
- R4: The permission field is {X,W,R}: bit 0 allows loads (`req_type`=0), bit 1 allows stores (1) and bit 2 allows fetches (2). `req_type`=3 is always denied. A matching entry's bits apply in every privilege mode, machine mode included.
- R5: Match mode 1 (top of range) matches granule g when lo <= g < addr. Here lo is the previous entry's address field, whatever that entry's mode, and lo is 0 for entry 0.
- R6: Match mode 2 (naturally aligned power of two) works on the address field. If the field has t trailing one bits, the entry covers 2^(t+1) granules. These granules share the field's bits above position t.
- R7: An entry in match mode 0 (off) or 3 (reserved) matches no address.
- R8: When several entries match, the lowest-numbered matching entry alone decides the verdict.
- R9: When no entry matches, a machine-mode request of type 0 to 2 is allowed, and every lower-privilege request is denied.
- R10: `grant` requires both this block's verdict and `attr_ok`=1. With `attr_ok`=0 the request faults.
- R11: A request sampled with `req_valid`=1 produces, one cycle later, either `grant`=1, or `fault`=1 with `fault_type` equal to its `req_type`. A cycle without a request leaves all three at 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_priv | input | 2 | Privilege of the writer (2'b11 machine) |
| cfg_idx | input | 4 | Entry to write |
| cfg_mode | input | 2 | Match mode: 0 off, 1 top of range, 2 power of two, 3 reserved |
| cfg_perm | input | 3 | Permission bits {X,W,R} |
| cfg_addr | input | 22 | Entry address field in 1 KB granules |
| req_valid | input | 1 | Access request present |
| req_priv | input | 2 | Privilege of the access (2'b11 machine) |
| req_type | input | 2 | 0 load, 1 store, 2 fetch, 3 reserved |
| req_gaddr | input | 22 | Access address in 1 KB granules |
| attr_ok | input | 1 | Verdict of the external attribute check |
| grant | output | 1 | Access granted (one cycle after request) |
| fault | output | 1 | Access denied (one cycle after request) |
| fault_type | output | 2 | Access type of the denied request |
| cfg_illegal | output | 1 | Previous cycle held a configuration write from below machine mode |

## Verification
The bench checks the top-of-range bounds at the last granule inside a range and the first granule past it. If the upper bound were inclusive, or if entry 0 took some bound other than 0, a grant would appear where a fault belongs. It also covers an all-ones power-of-two field, which has to cover the whole space without wrapping, and an off entry whose address still bounds its neighbour. A priority error would let a wide permissive entry override a narrow restrictive one. Finally, it sends a user-mode write that would open all memory, and a wrong privilege gate would show up as user accesses being granted afterwards.

// File: rtl/pmp_pkg.sv
package pmp_pkg;

  typedef enum logic [1:0] {
    MM_OFF   = 2'd0,
    MM_TOR   = 2'd1,
    MM_NAPOT = 2'd2,
    MM_RSVD  = 2'd3
  } match_mode_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_type_e;

  localparam logic [1:0] PRIV_MACHINE = 2'b11;

  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;

  // Select the permission bit that governs one access type.
  function automatic logic perm_allows(input logic [2:0] perm, input logic [1:0] acc);
    case (acc)
      ACC_LOAD:  return perm[PERM_R];
      ACC_STORE: return perm[PERM_W];
      ACC_FETCH: return perm[PERM_X];
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pmp_cfg_regs.sv
module pmp_cfg_regs
  import pmp_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int GW          = 22,
  parameter int IW          = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic [1:0]                       cfg_priv,
  input  logic [IW-1:0]                    cfg_idx,
  input  logic [1:0]                       cfg_mode,
  input  logic [2:0]                       cfg_perm,
  input  logic [GW-1:0]                    cfg_addr,
  output logic [NUM_ENTRIES-1:0][1:0]      mode_q,
  output logic [NUM_ENTRIES-1:0][2:0]      perm_q,
  output logic [NUM_ENTRIES-1:0][GW-1:0]   addr_q,
  output logic                             cfg_illegal
);

  logic idx_ok;
  logic wr_legal;
  logic wr_illegal;

  assign idx_ok     = (32'(cfg_idx) < NUM_ENTRIES);
  assign wr_legal   = cfg_we && (cfg_priv == PRIV_MACHINE) && idx_ok;
  assign wr_illegal = cfg_we && (cfg_priv != PRIV_MACHINE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= '0;
      perm_q      <= '0;
      addr_q      <= '0;
      cfg_illegal <= 1'b0;
    end else begin
      if (wr_legal) begin
        mode_q[cfg_idx] <= cfg_mode;
        perm_q[cfg_idx] <= cfg_perm;
        addr_q[cfg_idx] <= cfg_addr;
      end
      cfg_illegal <= wr_illegal;
    end
  end

  // R3: a lower-mode write leaves the whole table as it was
  p_lowpriv_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_priv != PRIV_MACHINE) |=>
      ($stable(mode_q) && $stable(perm_q) && $stable(addr_q) && cfg_illegal));

  // R3: flag only after a rejected write
  p_flag_only_on_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_priv != PRIV_MACHINE) |=> !cfg_illegal);

  // R2: a machine-mode write lands in the addressed entry
  p_legal_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_legal |=> (addr_q[$past(cfg_idx)] == $past(cfg_addr)) &&
                 (perm_q[$past(cfg_idx)] == $past(cfg_perm)) &&
                 (mode_q[$past(cfg_idx)] == $past(cfg_mode)));

endmodule

// File: rtl/pmp_entry_match.sv
module pmp_entry_match
  import pmp_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int GW          = 22
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [GW-1:0]                    gidx,
  input  logic [NUM_ENTRIES-1:0][1:0]      mode_q,
  input  logic [NUM_ENTRIES-1:0][GW-1:0]   addr_q,
  output logic [NUM_ENTRIES-1:0]           hit_vec
);

  // Power-of-two region: bits above the lowest zero of the field must agree.
  function automatic logic napot_hit(input logic [GW-1:0] g, input logic [GW-1:0] a);
    logic [GW-1:0] care;
    care = ~(a ^ (a + GW'(1)));
    return ((g ^ a) & care) == '0;
  endfunction

  // Top-of-range region: lower bound inclusive, upper bound exclusive.
  function automatic logic tor_hit(input logic [GW-1:0] g, input logic [GW-1:0] lo,
                                   input logic [GW-1:0] hi);
    return (g >= lo) && (g < hi);
  endfunction

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    logic [GW-1:0] lo_bound;
    logic          h;

    if (i == 0) begin : g_first
      assign lo_bound = '0;
    end else begin : g_rest
      assign lo_bound = addr_q[i-1];
    end

    always_comb begin
      case (mode_q[i])
        MM_TOR:   h = tor_hit(gidx, lo_bound, addr_q[i]);
        MM_NAPOT: h = napot_hit(gidx, addr_q[i]);
        default:  h = 1'b0;
      endcase
    end

    assign hit_vec[i] = h;

    // R7: an off or reserved entry never matches
    p_off_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[i] == MM_OFF || mode_q[i] == MM_RSVD) |-> !hit_vec[i]);

    // R5: an empty or inverted range matches nothing
    p_tor_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[i] == MM_TOR && addr_q[i] <= lo_bound) |-> !hit_vec[i]);

    // R6: the field's own granule is always inside its power-of-two region
    p_napot_self_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[i] == MM_NAPOT && gidx == addr_q[i]) |-> hit_vec[i]);
  end

endmodule

// File: rtl/pmp_priority_sel.sv
module pmp_priority_sel #(
  parameter int NUM_ENTRIES = 16,
  parameter int IW          = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_ENTRIES-1:0]       hit_vec,
  input  logic [NUM_ENTRIES-1:0][2:0]  perm_q,
  output logic                         any_hit,
  output logic [2:0]                   sel_perm
);

  logic [IW-1:0]          sel_idx;
  logic [NUM_ENTRIES-1:0] below_mask;

  // Scan from the top so the lowest matching index is written last.
  always_comb begin
    any_hit  = 1'b0;
    sel_idx  = '0;
    sel_perm = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_hit  = 1'b1;
        sel_idx  = IW'(i);
        sel_perm = perm_q[i];
      end
    end
  end

  assign below_mask = (NUM_ENTRIES'(1) << sel_idx) - NUM_ENTRIES'(1);

  // R8: the chosen entry matches and no lower entry does
  p_sel_is_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> hit_vec[sel_idx]);

  p_sel_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> ((hit_vec & below_mask) == '0));

  // R9: with no selection reported, no entry may be matching
  p_none_means_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !any_hit |-> (hit_vec == '0));

endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
  import pmp_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int ADDR_W      = 32,
  parameter int GRAN_LOG2   = 10,
  localparam int GW         = ADDR_W - GRAN_LOG2,
  localparam int IW         = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_priv,
  input  logic [IW-1:0] cfg_idx,
  input  logic [1:0]    cfg_mode,
  input  logic [2:0]    cfg_perm,
  input  logic [GW-1:0] cfg_addr,
  input  logic          req_valid,
  input  logic [1:0]    req_priv,
  input  logic [1:0]    req_type,
  input  logic [GW-1:0] req_gaddr,
  input  logic          attr_ok,
  output logic          grant,
  output logic          fault,
  output logic [1:0]    fault_type,
  output logic          cfg_illegal
);

  logic [NUM_ENTRIES-1:0][1:0]    mode_q;
  logic [NUM_ENTRIES-1:0][2:0]    perm_q;
  logic [NUM_ENTRIES-1:0][GW-1:0] addr_q;
  logic [NUM_ENTRIES-1:0]         hit_vec;
  logic                           any_hit;
  logic [2:0]                     sel_perm;
  logic                           pmp_ok;
  logic                           allow;

  pmp_cfg_regs #(.NUM_ENTRIES(NUM_ENTRIES), .GW(GW), .IW(IW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_priv(cfg_priv),
    .cfg_idx(cfg_idx), .cfg_mode(cfg_mode), .cfg_perm(cfg_perm),
    .cfg_addr(cfg_addr), .mode_q(mode_q), .perm_q(perm_q),
    .addr_q(addr_q), .cfg_illegal(cfg_illegal)
  );

  pmp_entry_match #(.NUM_ENTRIES(NUM_ENTRIES), .GW(GW)) u_match (
    .clk(clk), .rst_n(rst_n), .gidx(req_gaddr), .mode_q(mode_q),
    .addr_q(addr_q), .hit_vec(hit_vec)
  );

  pmp_priority_sel #(.NUM_ENTRIES(NUM_ENTRIES), .IW(IW)) u_sel (
    .clk(clk), .rst_n(rst_n), .hit_vec(hit_vec), .perm_q(perm_q),
    .any_hit(any_hit), .sel_perm(sel_perm)
  );

  // Matched entry governs every mode; unmatched space is open to machine mode only.
  assign pmp_ok = any_hit ? perm_allows(sel_perm, req_type)
                          : ((req_priv == PRIV_MACHINE) && (req_type != ACC_RSVD));
  assign allow  = pmp_ok && attr_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant      <= 1'b0;
      fault      <= 1'b0;
      fault_type <= 2'd0;
    end else begin
      grant      <= req_valid && allow;
      fault      <= req_valid && !allow;
      fault_type <= (req_valid && !allow) ? req_type : 2'd0;
    end
  end

  // R10: attribute veto always turns a request into a fault
  p_attr_veto_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !attr_ok) |=> (fault && !grant));

  // R11: no request, no response
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!grant && !fault && fault_type == 2'd0));

  // R11: a request yields exactly one of grant or fault, tagged with its type
  p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ((grant != fault) && (!fault || fault_type == $past(req_type))));

  // R9: unmatched lower-privilege access faults
  p_unmatched_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !any_hit && req_priv != PRIV_MACHINE) |=> fault);

  // R4: reserved type never granted
  p_rsvd_type_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_type == ACC_RSVD) |=> !grant);

endmodule

// File: tb/pmp_checker_tb_top.sv
module pmp_checker_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NE = 16;
  localparam int GW = 22;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [1:0]    cfg_priv;
  logic [3:0]    cfg_idx;
  logic [1:0]    cfg_mode;
  logic [2:0]    cfg_perm;
  logic [GW-1:0] cfg_addr;
  logic          req_valid;
  logic [1:0]    req_priv;
  logic [1:0]    req_type;
  logic [GW-1:0] req_gaddr;
  logic          attr_ok;
  logic          grant, fault, cfg_illegal;
  logic [1:0]    fault_type;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmp_checker dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_priv(cfg_priv),
    .cfg_idx(cfg_idx), .cfg_mode(cfg_mode), .cfg_perm(cfg_perm),
    .cfg_addr(cfg_addr), .req_valid(req_valid), .req_priv(req_priv),
    .req_type(req_type), .req_gaddr(req_gaddr), .attr_ok(attr_ok),
    .grant(grant), .fault(fault), .fault_type(fault_type),
    .cfg_illegal(cfg_illegal)
  );

  int checks = 0;
  int fails  = 0;

  // Behavioural model of the entry table
  int md[NE];
  int pm[NE];
  int ad[NE];

  bit    exp_armed = 0;
  bit    exp_grant, exp_fault, exp_ill;
  int    exp_ftype;
  string exp_tag;

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit model_hit(int i, int g);
    int lo, t, sh;
    if (md[i] == 1) begin
      lo = (i == 0) ? 0 : ad[i-1];
      return (g >= lo) && (g < ad[i]);
    end
    if (md[i] == 2) begin
      t = 0;
      while (t < GW && ((ad[i] >> t) & 1) == 1) t++;
      sh = t + 1;
      if (sh >= GW) return 1'b1;
      return (g >> sh) == (ad[i] >> sh);
    end
    return 1'b0;
  endfunction

  function automatic bit model_ok(int priv, int typ, int g);
    for (int i = 0; i < NE; i++) begin
      if (model_hit(i, g)) return (typ < 3) && (((pm[i] >> typ) & 1) == 1);
    end
    return (priv == 3) && (typ < 3);
  endfunction

  task automatic drive(string tag, bit we, int cp, int ci, int cm, int cpm, int ca,
                       bit rv, int rp, int rt, int rg, bit at);
    bit ok;
    @(negedge clk);
    if (exp_armed) begin
      check(exp_tag, "grant", int'(grant), int'(exp_grant));
      check(exp_tag, "fault", int'(fault), int'(exp_fault));
      check(exp_tag, "fault_type", int'(fault_type), exp_ftype);
      check(exp_tag, "cfg_illegal", int'(cfg_illegal), int'(exp_ill));
    end
    cfg_we = we; cfg_priv = 2'(cp); cfg_idx = 4'(ci); cfg_mode = 2'(cm);
    cfg_perm = 3'(cpm); cfg_addr = GW'(ca);
    req_valid = rv; req_priv = 2'(rp); req_type = 2'(rt); req_gaddr = GW'(rg);
    attr_ok = at;
    ok = model_ok(rp, rt, rg) && at;
    exp_grant = rv && ok;
    exp_fault = rv && !ok;
    exp_ftype = (rv && !ok) ? rt : 0;
    exp_ill   = we && (cp != 3);
    if (we && cp == 3) begin
      md[ci] = cm; pm[ci] = cpm; ad[ci] = ca;
    end
    exp_tag = tag;
    exp_armed = 1;
  endtask

  task automatic cfgw(string tag, int priv, int idx, int mode, int perm, int addr);
    drive(tag, 1, priv, idx, mode, perm, addr, 0, 0, 0, 0, 1);
  endtask

  task automatic acc(string tag, int priv, int typ, int g, bit at);
    drive(tag, 0, 0, 0, 0, 0, 0, 1, priv, typ, g, at);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL R11 watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < NE; i++) begin md[i] = 0; pm[i] = 0; ad[i] = 0; end
    rst_n = 0; cfg_we = 0; cfg_priv = 0; cfg_idx = 0; cfg_mode = 0; cfg_perm = 0;
    cfg_addr = 0; req_valid = 1; req_priv = 0; req_type = 0; req_gaddr = 0; attr_ok = 0;
    repeat (3) @(negedge clk);
    check("R1", "grant in reset", int'(grant), 0);
    check("R1", "fault in reset", int'(fault), 0);
    check("R1", "cfg_illegal in reset", int'(cfg_illegal), 0);
    req_valid = 0;
    rst_n = 1;

    // R1 / R9: empty table
    acc("R1", 0, 0, 0, 1);
    acc("R9", 3, 0, 0, 1);
    acc("R9", 1, 2, 100, 1);
    acc("R9", 3, 3, 100, 1);

    // R3: user write that would open everything is rejected
    cfgw("R3", 0, 3, 2, 7, 22'h3FFFFF);
    acc("R3", 0, 0, 50, 1);
    cfgw("R3", 1, 0, 1, 7, 100);
    acc("R3", 1, 1, 10, 1);

    // R2 / R5 / R4: entry 0 top of range [0,4) read only
    cfgw("R2", 3, 0, 1, 1, 4);
    acc("R5", 0, 0, 3, 1);
    acc("R5", 0, 0, 4, 1);
    acc("R4", 0, 1, 0, 1);
    acc("R4", 0, 2, 0, 1);

    // R5: entry 1 top of range [4,8) all permissions
    cfgw("R2", 3, 1, 1, 7, 8);
    acc("R5", 0, 1, 4, 1);
    acc("R5", 0, 1, 7, 1);
    acc("R5", 0, 1, 8, 1);

    // R6: entry 2 power-of-two, field 65 -> granules 64..67, write+execute
    cfgw("R2", 3, 2, 2, 6, 65);
    acc("R6", 0, 1, 64, 1);
    acc("R6", 0, 2, 67, 1);
    acc("R6", 0, 1, 68, 1);
    acc("R6", 0, 1, 63, 1);
    acc("R4", 0, 0, 65, 1);
    acc("R4", 3, 0, 66, 1);

    // R8: entry 3 covers all space with all permissions
    cfgw("R6", 3, 3, 2, 7, 22'h3FFFFF);
    acc("R8", 0, 1, 0, 1);
    acc("R8", 1, 0, 65, 1);
    acc("R6", 0, 1, 22'h3FFFFF, 1);
    acc("R4", 0, 3, 200, 1);

    // R7: entry 0 switched off but its address still bounds entry 1
    cfgw("R7", 3, 0, 0, 1, 4);
    acc("R7", 0, 1, 0, 1);
    acc("R7", 0, 1, 3, 1);
    cfgw("R7", 3, 3, 3, 7, 22'h3FFFFF);
    acc("R7", 0, 1, 200, 1);

    // R10: attribute veto
    acc("R10", 0, 1, 5, 0);
    acc("R10", 0, 1, 5, 1);

    // Mixed traffic
    for (int n = 0; n < 800; n++) begin
      int r;
      r = $urandom % 100;
      if (r < 12)
        cfgw("R2", 3, $urandom % NE, $urandom % 4, $urandom % 8,
             (($urandom % 8) == 0) ? 22'h3FFFFF : ($urandom % 256));
      else if (r < 18)
        cfgw("R3", $urandom % 3, $urandom % NE, $urandom % 4, $urandom % 8, $urandom % 256);
      else if (r < 25)
        drive("R11", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
      else begin
        int p;
        p = $urandom % 3;
        if (p == 2) p = 3;
        acc("R11", p, $urandom % 4, $urandom % 300, ($urandom % 10) != 0);
      end
    end

    drive("R11", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    drive("R11", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    summary();
    $finish;
  end

endmodule